// File: doc/BRIEF.md
# Weighted-Sum Binary-to-BCD Converter

This block turns an unsigned binary number into packed binary-coded decimal over several clock cycles. It does not use the shift-and-correct method. It keeps a BCD accumulator. On each cycle it looks at one bit of the captured input. If that bit is set, it adds the decimal image of the bit's power of two to the accumulator. The addition is decimal: it works digit by digit, and any digit that goes past nine is corrected and carries into the next digit. The images of the powers of two are computed as constants when the design is elaborated, so no divider or lookup memory is needed at run time.

A conversion starts with a one-cycle start pulse, which also captures the input value. The input width is a parameter. The output has as many decimal digits as the largest input value needs. A done pulse marks the cycle in which the result becomes final. The result then stays on the output until the next start.

Top module: `bin2dec_wsum`

## Requirements
- R1: After reset, `bcd_o` is all zeros and `done_o` is low.
- R2: Every 4-bit digit group of `bcd_o` always holds a value from 0 to 9.
- R3: A digit addition whose raw sum (addend digits plus incoming carry) is 10 to 19 produces the raw sum minus ten and a carry of 1. This includes raw sums above 15. A raw sum of 9 or less passes through with no carry.
- R4: Every input bit i that is 1 adds the decimal value 2^i to the result, and bits that are 0 add nothing. The result equals the decimal value of the captured input, so an input of zero gives all-zero digits.
- R5: Digit d of the result sits at `bcd_o[4*d+3:4*d]`. Digit 0 (bits 3:0) is the units digit, bits 7:4 hold the tens, and so on upward.
- R6: With the default 8-bit width, an all-ones input gives the digits 2, 5, 5, which is `bcd_o` = 12'h255.
- R7: `bcd_o` reads zero in the cycle after a start is sampled.
- R8: `done_o` is high for exactly one cycle: the cycle after the BIN_W-th rising edge that follows the edge where start was sampled. It is low in the cycles between start and that point.
- R9: The input is captured at start, so later changes to `bin_i` have no effect. The final result stays on `bcd_o` until the next start.
- R10: A start during a running conversion abandons that conversion and begins a new one, with the same timing as R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request that captures `bin_i` and clears the accumulator |
| bin_i | input | BIN_W | Unsigned binary value to convert |
| done_o | output | 1 | One-cycle pulse marking a final result |
| bcd_o | output | 4*DIGITS | Packed BCD result, units digit in the lowest nibble |

## Verification
The decimal digit adder is driven with every legal pair of digits, with and without an incoming carry. This separates correct corrections from wrong ones for raw sums of 10 to 15 and of 16 to 19. Directed values are also used:
- zero, which shows that bits equal to 0 add nothing;
- a single low bit and a single high bit, which show the bit order and the digit positions;
- all ones, which shows carries running through every digit;
- 99, a decimal edge.

Several hundred random values from a seeded generator check the complete sum. During each of these runs `bin_i` is set to a different value, which shows that only the captured input counts. A start issued partway through a conversion shows that the old partial sum is dropped.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

   // Largest input width the constant arithmetic below can handle.
   localparam int MAX_BITS = 60;
   // Decimal digits needed for 2^MAX_BITS - 1.
   localparam int MAX_DIG  = 19;

   typedef logic [4*MAX_DIG-1:0] wide_bcd_t;

   // Number of decimal digits needed for the value 2^w - 1.
   function automatic int dec_digits(input int w);
      longint unsigned v;
      int n;
      v = (longint'(1) << w) - 1;
      n = 1;
      for (int k = 0; k < MAX_DIG; k++) begin
         if (v != 0) n = k + 1;
         v = v / 10;
      end
      return n;
   endfunction

   // Packed BCD form of 2^i, units digit in the lowest nibble.
   function automatic wide_bcd_t pow2_bcd(input int i);
      longint unsigned v;
      wide_bcd_t r;
      v = longint'(1) << i;
      r = '0;
      for (int d = 0; d < MAX_DIG; d++) begin
         r[4*d +: 4] = 4'(v % 10);
         v = v / 10;
      end
      return r;
   endfunction

endpackage

// File: rtl/bwc_digit_add.sv
module bwc_digit_add (
   input  logic [3:0] a_i,
   input  logic [3:0] b_i,
   input  logic       c_i,
   output logic [3:0] s_o,
   output logic       c_o
);
   logic [4:0] raw;

   always_comb begin
      raw = {1'b0, a_i} + {1'b0, b_i} + {4'd0, c_i};
      if (raw > 5'd9) begin
         // Adding six skips the unused codes 10 to 15; the fifth bit is the carry.
         s_o = 4'(raw + 5'd6);
         c_o = 1'b1;
      end else begin
         s_o = raw[3:0];
         c_o = 1'b0;
      end
   end
endmodule

// File: rtl/bwc_bcd_adder.sv
module bwc_bcd_adder #(
   parameter int DIGITS = 3
) (
   input  logic [4*DIGITS-1:0] a_i,
   input  logic [4*DIGITS-1:0] b_i,
   output logic [4*DIGITS-1:0] sum_o,
   output logic                ovf_o
);
   logic [DIGITS:0] chain;

   assign chain[0] = 1'b0;

   for (genvar d = 0; d < DIGITS; d++) begin : g_dig
      bwc_digit_add u_dig (
         .a_i (a_i[4*d +: 4]),
         .b_i (b_i[4*d +: 4]),
         .c_i (chain[d]),
         .s_o (sum_o[4*d +: 4]),
         .c_o (chain[d+1])
      );
   end

   assign ovf_o = chain[DIGITS];
endmodule

// File: rtl/bwc_weight_table.sv
module bwc_weight_table #(
   parameter int BIN_W  = 8,
   parameter int DIGITS = 3,
   localparam int IDX_W = (BIN_W > 1) ? $clog2(BIN_W) : 1
) (
   input  logic [IDX_W-1:0]    idx_i,
   output logic [4*DIGITS-1:0] img_o
);
   logic [4*DIGITS-1:0] rows [BIN_W];

   for (genvar i = 0; i < BIN_W; i++) begin : g_row
      localparam bwc_pkg::wide_bcd_t FULL = bwc_pkg::pow2_bcd(i);
      assign rows[i] = FULL[4*DIGITS-1:0];
   end

   always_comb begin
      if (int'(idx_i) < BIN_W) img_o = rows[idx_i];
      else                     img_o = '0;
   end
endmodule

// File: rtl/bwc_seq_ctrl.sv
module bwc_seq_ctrl #(
   parameter int BIN_W = 8,
   localparam int IDX_W = (BIN_W > 1) ? $clog2(BIN_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [BIN_W-1:0] bin_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             step_o,
   output logic             done_o
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(BIN_W - 1);

   logic             busy;
   logic [IDX_W-1:0] idx;
   logic [BIN_W-1:0] cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         idx    <= '0;
         cap    <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            busy <= 1'b1;
            idx  <= '0;
            cap  <= bin_i;
         end else if (busy) begin
            if (idx == LAST) begin
               busy   <= 1'b0;
               idx    <= '0;
               done_o <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   assign idx_o  = idx;
   assign step_o = busy & cap[idx];
endmodule

// File: rtl/bin2dec_wsum.sv
module bin2dec_wsum #(
   parameter  int BIN_W  = 8,
   localparam int DIGITS = bwc_pkg::dec_digits(BIN_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [BIN_W-1:0]    bin_i,
   output logic                done_o,
   output logic [4*DIGITS-1:0] bcd_o
);
   localparam int IDX_W = (BIN_W > 1) ? $clog2(BIN_W) : 1;

   if (BIN_W < 2 || BIN_W > bwc_pkg::MAX_BITS) begin : g_bad_width
      $error("bin2dec_wsum: BIN_W must lie in 2..%0d", bwc_pkg::MAX_BITS);
   end

   logic [IDX_W-1:0]    idx;
   logic                step;
   logic [4*DIGITS-1:0] img;
   logic [4*DIGITS-1:0] acc;
   logic [4*DIGITS-1:0] acc_nxt;
   logic                add_ovf;

   bwc_seq_ctrl #(.BIN_W(BIN_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .bin_i   (bin_i),
      .idx_o   (idx),
      .step_o  (step),
      .done_o  (done_o)
   );

   bwc_weight_table #(.BIN_W(BIN_W), .DIGITS(DIGITS)) u_tab (
      .idx_i (idx),
      .img_o (img)
   );

   bwc_bcd_adder #(.DIGITS(DIGITS)) u_add (
      .a_i   (acc),
      .b_i   (img),
      .sum_o (acc_nxt),
      .ovf_o (add_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc <= '0;
      else if (start_i) acc <= '0;
      else if (step)    acc <= acc_nxt;
   end

   assign bcd_o = acc;
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker #(
   parameter int BIN_W  = 8,
   parameter int DIGITS = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic                done_o,
   input logic [4*DIGITS-1:0] bcd_o,
   input logic                ovf_i
);
   localparam int CW = $clog2(BIN_W + 1);

   logic          run;
   logic          fin;
   logic [CW-1:0] cnt;

   // Independent count of edges since the last start.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         fin <= 1'b0;
         cnt <= '0;
      end else begin
         fin <= 1'b0;
         if (start_i) begin
            run <= 1'b1;
            cnt <= '0;
         end else if (run) begin
            if (int'(cnt) == BIN_W - 1) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
            cnt <= cnt + 1'b1;
         end
      end
   end

   function automatic bit digits_legal(input logic [4*DIGITS-1:0] v);
      for (int d = 0; d < DIGITS; d++)
         if (v[4*d +: 4] > 4'd9) return 1'b0;
      return 1'b1;
   endfunction

   a_r2_digit_legal: assert property (@(posedge clk) disable iff (!rst_n)
      digits_legal(bcd_o));

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_i);

   a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (bcd_o == '0));

   a_r8_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
      done_o == fin);

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start_i) |=> $stable(bcd_o));
endmodule

bind bin2dec_wsum bwc_checker #(.BIN_W(BIN_W), .DIGITS(DIGITS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .done_o  (done_o),
   .bcd_o   (bcd_o),
   .ovf_i   (add_ovf)
);

// File: tb/bin2dec_wsum_tb_top.sv
module bin2dec_wsum_tb_top;
   localparam int BIN_W = 8;

   function automatic int tb_digits(input int w);
      longint unsigned v;
      int n;
      v = (longint'(1) << w) - 1;
      n = 0;
      while (v != 0) begin
         n++;
         v = v / 10;
      end
      return (n == 0) ? 1 : n;
   endfunction

   localparam int DG = tb_digits(BIN_W);

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic [BIN_W-1:0]    bin = '0;
   logic                done;
   logic [4*DG-1:0]     bcd;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   always #4 clk = ~clk;

   bin2dec_wsum #(.BIN_W(BIN_W)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .bin_i   (bin),
      .done_o  (done),
      .bcd_o   (bcd)
   );

   // Stand-alone digit adder for the exhaustive correction test.
   logic [3:0] da, db, ds;
   logic       dc, dco;
   bwc_digit_add u_dig (.a_i(da), .b_i(db), .c_i(dc), .s_o(ds), .c_o(dco));

   function automatic logic [4*DG-1:0] exp_bcd(input longint unsigned v);
      logic [4*DG-1:0] r;
      r = '0;
      for (int d = 0; d < DG; d++) begin
         r[4*d +: 4] = 4'(v % 10);
         v = v / 10;
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // Converts v; bin_i is scrambled after start to exercise capture (R9).
   task automatic run_conv(input logic [BIN_W-1:0] v);
      bit early;
      logic [4*DG-1:0] e;
      e = exp_bcd(longint'(v));
      @(negedge clk);
      start = 1'b1;
      bin   = v;
      @(negedge clk);
      start = 1'b0;
      bin   = ~v;
      chk(bcd == '0, "R7 cleared after start", longint'(bcd), 0);
      early = 1'b0;
      for (int i = 1; i <= BIN_W; i++) begin
         @(negedge clk);
         if (i < BIN_W && done) early = 1'b1;
         if (i == BIN_W / 2) bin = BIN_W'($urandom);
      end
      chk(!early && done, "R8 done timing", longint'({early, done}), 1);
      chk(bcd == e, "R4 R2 result value", longint'(bcd), longint'(e));
      @(negedge clk);
      chk(!done && bcd == e, "R9 result held, done single",
          longint'({done, bcd}), longint'(e));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      chk(bcd == '0 && !done, "R1 reset state", longint'({done, bcd}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bcd == '0 && !done, "R1 idle after reset", longint'({done, bcd}), 0);

      // R3: all legal digit pairs with and without carry in.
      for (int a = 0; a < 10; a++)
         for (int b = 0; b < 10; b++)
            for (int c = 0; c < 2; c++) begin
               int raw;
               da = 4'(a); db = 4'(b); dc = c[0];
               #1;
               raw = a + b + c;
               chk(ds == 4'((raw > 9) ? raw - 10 : raw) && dco == (raw > 9),
                   "R3 digit correction", longint'({dco, ds}),
                   longint'({1'(raw > 9), 4'((raw > 9) ? raw - 10 : raw)}));
            end

      run_conv('0);                       // R4 zero bits add nothing
      run_conv(BIN_W'(1));                // R5 units digit in bits 3:0
      chk(bcd[3:0] == 4'd1, "R5 units position", longint'(bcd), 1);
      run_conv(BIN_W'(128));              // R5 highest bit
      chk(bcd == 12'h128, "R5 digit order", longint'(bcd), 'h128);
      run_conv('1);                       // R6 all ones
      chk(bcd == 12'h255, "R6 all ones", longint'(bcd), 'h255);
      run_conv(BIN_W'(99));
      run_conv(BIN_W'(100));

      // R10: restart mid conversion.
      @(negedge clk);
      start = 1'b1;
      bin   = BIN_W'(200);
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk(!done, "R10 no done before restart", longint'(done), 0);
      run_conv(BIN_W'(37));
      chk(bcd == 12'h037, "R10 restart result", longint'(bcd), 'h37);

      for (int k = 0; k < 300; k++) run_conv(BIN_W'($urandom));

      finish_run();
   end
endmodule